// File: doc/BRIEF.md
# PCI Slot Hotplug Register Block

This block keeps the hotplug bookkeeping for a bank of PCI slots on one bus: which slots hold a device, which slots wait for software to remove their device, and which slots allow hot removal at all. Firmware reaches it through a small I/O window of 32-bit registers. The platform reports slot events on strobe inputs: a device arriving at run time, a device leaving, or a device found present at boot. Run-time events set a general-purpose event status flag that the interrupt logic elsewhere turns into a system interrupt.

Software retires a pending removal by writing a slot mask to the eject port. The block picks one slot from that mask and presents it on an eject request output, so that logic outside the block can tear the device down. A second input marks slots whose devices cannot be freed. A machine-level reset request makes the block retire every pending removal, one slot per cycle, and then rebuild its masks from the current bus population. The device-check register is not stored: it is formed on each read from the present mask and the removable mask.

Top module: `slot_hotplug_regs`

## Requirements
- R1: While `rst_n` is low and in the cycle it is released, `rd_data`, `eject_v` and `gpe_hp_sts` are 0. In the first clock after release the block loads the present mask from `occupied` and the removable mask from the inverse of `fixed_slots`.
- R2: A read (`rd_en`) at offset 0x0 returns, on `rd_data` one cycle later, the present mask ANDed with the removable mask. `rd_data` holds its value between reads.
- R3: A read at offset 0x4 returns the pending-removal mask, offset 0xC returns the removable mask, and offset 0x8 returns 0. A read at any other offset, including one with `addr[1:0]` nonzero, returns 0.
- R4: A write to offset 0x8 with nonzero data picks the lowest set bit of the data as the slot, clears that slot's pending-removal bit, and pulses `eject_v` for one cycle with `eject_slot` naming the slot, one cycle after the write. A write of zero does nothing.
- R5: During an eject, a slot whose bit in `fixed_slots` is set at that moment keeps its present bit. Any other ejected slot loses its present bit.
- R6: `hot_add` sets the present bit of `evt_slot` and `hot_remove` sets its pending-removal bit. Both set `gpe_hp_sts`. When an eject hits the same bit in the same cycle, the event's set wins.
- R7: `cold_add` sets the present bit of `evt_slot` and leaves `gpe_hp_sts` unchanged.
- R8: `gpe_hp_sts` stays set until a cycle with `gpe_ack` high clears it. A run-time event in the same cycle as `gpe_ack` leaves it set.
- R9: After a `plat_rst` pulse the block ejects every pending-removal slot, lowest slot first, one per cycle, each with an `eject_v` pulse. It then spends one cycle with no work and one rebuild cycle that reloads the masks as in R1. From the cycle after the pulse until the rebuild has completed, eject writes and slot events are ignored.
- R10: Writes to any offset other than 0x8, and writes with `addr[1:0]` nonzero, change no state and raise no eject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (4) | Byte offset in the I/O window |
| wr_data | input | REG_W (32) | Write data |
| rd_data | output | REG_W (32) | Registered read data |
| hot_add | input | 1 | Run-time device insertion at `evt_slot` |
| hot_remove | input | 1 | Run-time removal request at `evt_slot` |
| cold_add | input | 1 | Boot-time device present at `evt_slot` |
| evt_slot | input | SLOT_W (5) | Slot number for the event strobes |
| occupied | input | NUM_SLOTS (32) | Slots currently holding a device, used at rebuild |
| fixed_slots | input | NUM_SLOTS (32) | Slots whose devices cannot be hot removed or freed |
| plat_rst | input | 1 | Machine reset request: flush removals, then rebuild |
| gpe_ack | input | 1 | Clears the event status flag |
| gpe_hp_sts | output | 1 | Hotplug event status flag |
| eject_v | output | 1 | Eject request valid (one cycle) |
| eject_slot | output | SLOT_W (5) | Slot to tear down |

## Verification
The collision that matters is a slot event and a software eject that touch the same slot in the same cycle. Examples are a removal request arriving just as firmware ejects that slot, or an insertion landing on a slot being ejected. The bench drives these pairs directly, and the random phase makes them often by aiming events and eject masks at a narrow slot range. A reference model that applies the clear first and then the set judges the result through later reads of the present and pending-removal registers. Event strobes that coincide with `gpe_ack`, and eject writes that arrive during a flush, are judged the same way.

// File: rtl/slot_hp_pkg.sv
// Package: shared phase type and I/O window offsets for the slot hotplug block.
// Assumes: offsets are byte addresses of 32-bit registers.
package slot_hp_pkg;

    typedef enum logic [1:0] {
        PH_RUN     = 2'd0,
        PH_FLUSH   = 2'd1,
        PH_REBUILD = 2'd2
    } hp_phase_e;

    localparam int OFS_CHECK  = 'h0;
    localparam int OFS_REMOVE = 'h4;
    localparam int OFS_EJECT  = 'h8;
    localparam int OFS_REMOV  = 'hC;

endpackage

// File: rtl/slot_hp_lowbit.sv
// Module: lowest-set-bit finder.
// Gives a one-hot mask of the lowest set bit of vec, its index, and a found flag.
// Assumes: IW is wide enough to hold N-1.
module slot_hp_lowbit #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);

    logic [N:0] below;

    assign below[0] = 1'b0;

    // one stage per bit: accumulate "any lower bit set" and isolate the first one
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign below[g+1] = below[g] | vec[g];
        assign onehot[g]  = vec[g] & ~below[g];
    end

    assign found = below[N];

    // encode the one-hot mask into a slot index
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | IW'(i);
        end
    end

endmodule

// File: rtl/slot_hp_state.sv
// Module: slot state keeper.
// Holds present, pending-removal and removable masks, the event status flag,
// the run/flush/rebuild phase and the eject request register.
// Assumes: ej_req is already decoded from the bus; event strobes name one slot.
module slot_hp_state
    import slot_hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ej_req,
    input  logic [NUM_SLOTS-1:0] ej_bits,
    input  logic                 hot_add,
    input  logic                 hot_remove,
    input  logic                 cold_add,
    input  logic [SLOT_W-1:0]    evt_slot,
    input  logic [NUM_SLOTS-1:0] occupied,
    input  logic [NUM_SLOTS-1:0] fixed_slots,
    input  logic                 plat_rst,
    input  logic                 gpe_ack,
    output logic [NUM_SLOTS-1:0] present,
    output logic [NUM_SLOTS-1:0] down_mask,
    output logic [NUM_SLOTS-1:0] hp_enable,
    output hp_phase_e            phase,
    output logic                 gpe_hp_sts,
    output logic                 eject_v,
    output logic [SLOT_W-1:0]    eject_slot
);

    logic [NUM_SLOTS-1:0] pick_vec, pick_hot, clr_mask, evt_hot;
    logic [NUM_SLOTS-1:0] present_n, down_n, enable_n;
    logic [SLOT_W-1:0]    pick_idx, slot_n;
    logic                 pick_found, take_ej, ev_ok, gpe_n;
    hp_phase_e            phase_n;

    // a flush walks the pending mask, otherwise software's written mask is used
    assign pick_vec = (phase == PH_FLUSH) ? down_mask : ej_bits;

    slot_hp_lowbit #(.N(NUM_SLOTS), .IW(SLOT_W)) u_pick (
        .vec    (pick_vec),
        .found  (pick_found),
        .idx    (pick_idx),
        .onehot (pick_hot)
    );

    assign ev_ok   = (phase == PH_RUN);
    assign take_ej = pick_found && ((ev_ok && ej_req) || (phase == PH_FLUSH));
    assign evt_hot = NUM_SLOTS'(1) << evt_slot;

    // next-state masks: eject clears first, then events set (set wins)
    always_comb begin
        clr_mask  = take_ej ? pick_hot : '0;
        present_n = present & ~(clr_mask & ~fixed_slots);
        down_n    = down_mask & ~clr_mask;
        enable_n  = hp_enable;
        if (ev_ok && (hot_add || cold_add)) present_n = present_n | evt_hot;
        if (ev_ok && hot_remove)            down_n    = down_n | evt_hot;
        if (phase == PH_REBUILD) begin
            present_n = occupied;
            enable_n  = ~fixed_slots;
        end
    end

    // phase sequencing: run -> flush (until empty) -> rebuild -> run
    always_comb begin
        phase_n = phase;
        unique case (phase)
            PH_RUN:     if (plat_rst) phase_n = PH_FLUSH;
            PH_FLUSH:   if (down_mask == '0) phase_n = PH_REBUILD;
            PH_REBUILD: phase_n = PH_RUN;
            default:    phase_n = PH_RUN;
        endcase
    end

    // event flag: run-time event sets, acknowledge clears, set has priority
    assign gpe_n  = (ev_ok && (hot_add || hot_remove)) ? 1'b1 :
                    (gpe_ack ? 1'b0 : gpe_hp_sts);
    assign slot_n = take_ej ? pick_idx : eject_slot;

    // state registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present    <= '0;
            down_mask  <= '0;
            hp_enable  <= '1;
            phase      <= PH_REBUILD;
            gpe_hp_sts <= 1'b0;
            eject_v    <= 1'b0;
            eject_slot <= '0;
        end else begin
            present    <= present_n;
            down_mask  <= down_n;
            hp_enable  <= enable_n;
            phase      <= phase_n;
            gpe_hp_sts <= gpe_n;
            eject_v    <= take_ej;
            eject_slot <= slot_n;
        end
    end

endmodule

// File: rtl/slot_hp_rdmux.sv
// Module: registered read decoder for the hotplug I/O window.
// Forms the device-check value on the fly; unaligned or unknown offsets read 0.
// Assumes: NUM_SLOTS <= REG_W.
module slot_hp_rdmux
    import slot_hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int REG_W     = 32,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_SLOTS-1:0] present,
    input  logic [NUM_SLOTS-1:0] down_mask,
    input  logic [NUM_SLOTS-1:0] hp_enable,
    output logic [REG_W-1:0]     rd_data
);

    logic [REG_W-1:0] rd_val;

    // select the register value for the addressed offset
    always_comb begin
        rd_val = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == ADDR_W'(OFS_CHECK))
                rd_val[NUM_SLOTS-1:0] = present & hp_enable;
            else if (addr == ADDR_W'(OFS_REMOVE))
                rd_val[NUM_SLOTS-1:0] = down_mask;
            else if (addr == ADDR_W'(OFS_REMOV))
                rd_val[NUM_SLOTS-1:0] = hp_enable;
        end
    end

    // capture read data on a read strobe, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_val;
    end

endmodule

// File: rtl/slot_hotplug_regs.sv
// Module: PCI slot hotplug register block (top).
// Decodes the eject port write, keeps slot state, and serves register reads.
// Assumes: only full 32-bit aligned accesses carry meaning.
module slot_hotplug_regs
    import slot_hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int REG_W     = 32,
    parameter int ADDR_W    = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    input  logic                 hot_add,
    input  logic                 hot_remove,
    input  logic                 cold_add,
    input  logic [SLOT_W-1:0]    evt_slot,
    input  logic [NUM_SLOTS-1:0] occupied,
    input  logic [NUM_SLOTS-1:0] fixed_slots,
    input  logic                 plat_rst,
    input  logic                 gpe_ack,
    output logic                 gpe_hp_sts,
    output logic                 eject_v,
    output logic [SLOT_W-1:0]    eject_slot
);

    logic [NUM_SLOTS-1:0] present, down_mask, hp_enable;
    hp_phase_e            phase;
    logic                 ej_req;

    // only an aligned write to the eject port does anything
    assign ej_req = wr_en && (addr == ADDR_W'(OFS_EJECT));

    slot_hp_state #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .ej_req      (ej_req),
        .ej_bits     (wr_data[NUM_SLOTS-1:0]),
        .hot_add     (hot_add),
        .hot_remove  (hot_remove),
        .cold_add    (cold_add),
        .evt_slot    (evt_slot),
        .occupied    (occupied),
        .fixed_slots (fixed_slots),
        .plat_rst    (plat_rst),
        .gpe_ack     (gpe_ack),
        .present     (present),
        .down_mask   (down_mask),
        .hp_enable   (hp_enable),
        .phase       (phase),
        .gpe_hp_sts  (gpe_hp_sts),
        .eject_v     (eject_v),
        .eject_slot  (eject_slot)
    );

    slot_hp_rdmux #(.NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .addr      (addr),
        .present   (present),
        .down_mask (down_mask),
        .hp_enable (hp_enable),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/slot_hp_chk.sv
// Checker: temporal properties of the slot hotplug block, bound to the top.
// Assumes: default parameters are propagated by the bind below.
module slot_hp_chk
    import slot_hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int REG_W     = 32,
    parameter int ADDR_W    = 4,
    parameter int SLOT_W    = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_en,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [REG_W-1:0]     wr_data,
    input logic [REG_W-1:0]     rd_data,
    input logic                 hot_add,
    input logic                 hot_remove,
    input logic                 cold_add,
    input logic [SLOT_W-1:0]    evt_slot,
    input logic [NUM_SLOTS-1:0] occupied,
    input logic [NUM_SLOTS-1:0] fixed_slots,
    input logic                 gpe_hp_sts,
    input logic                 eject_v,
    input logic [SLOT_W-1:0]    eject_slot,
    input logic [NUM_SLOTS-1:0] present,
    input logic [NUM_SLOTS-1:0] hp_enable,
    input hp_phase_e            phase
);

    logic [NUM_SLOTS-1:0] prev_present, prev_fixed;
    logic [NUM_SLOTS-1:0] prev_wr;

    // one-cycle history of state and inputs seen at the eject edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_present <= '0;
            prev_fixed   <= '0;
            prev_wr      <= '0;
        end else begin
            prev_present <= present;
            prev_fixed   <= fixed_slots;
            prev_wr      <= wr_data[NUM_SLOTS-1:0];
        end
    end

    // R2
    check_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == ADDR_W'(OFS_CHECK) |=> rd_data == REG_W'($past(present & hp_enable)));

    // R4
    eject_lowbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == ADDR_W'(OFS_EJECT) && wr_data[NUM_SLOTS-1:0] != '0 && phase == PH_RUN
        |=> eject_v && prev_wr[eject_slot]
            && ((prev_wr & ((NUM_SLOTS'(1) << eject_slot) - NUM_SLOTS'(1))) == '0));

    // R5
    fixed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eject_v && prev_fixed[eject_slot] && prev_present[eject_slot] |-> present[eject_slot]);

    // R6
    hot_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hot_add && phase == PH_RUN |=> gpe_hp_sts && present[$past(evt_slot)]);

    // R7
    cold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cold_add && !hot_add && !hot_remove && !gpe_hp_sts && phase == PH_RUN
        |=> !gpe_hp_sts && present[$past(evt_slot)]);

    // R9
    rebuild_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_REBUILD |=> present == $past(occupied) && hp_enable == ~$past(fixed_slots));

endmodule

bind slot_hotplug_regs slot_hp_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .REG_W     (REG_W),
    .ADDR_W    (ADDR_W),
    .SLOT_W    (SLOT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .addr        (addr),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .hot_add     (hot_add),
    .hot_remove  (hot_remove),
    .cold_add    (cold_add),
    .evt_slot    (evt_slot),
    .occupied    (occupied),
    .fixed_slots (fixed_slots),
    .gpe_hp_sts  (gpe_hp_sts),
    .eject_v     (eject_v),
    .eject_slot  (eject_slot),
    .present     (present),
    .hp_enable   (hp_enable),
    .phase       (phase)
);

// File: tb/sim_slot_hotplug_regs.sv
// Bench: directed corner cases plus seeded random traffic against a reference model.
module sim_slot_hotplug_regs;

    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        hot_add = 1'b0, hot_remove = 1'b0, cold_add = 1'b0;
    logic [4:0]  evt_slot = '0;
    logic [31:0] occupied = '0, fixed_slots = '0;
    logic        plat_rst = 1'b0, gpe_ack = 1'b0;
    logic        gpe_hp_sts, eject_v;
    logic [4:0]  eject_slot;

    int n_chk = 0, n_bad = 0;
    int cycles = 0;
    bit finished = 0;

    // reference model state
    logic [31:0] m_pres, m_down, m_en, m_rd;
    logic        m_gpe, m_ev;
    logic [4:0]  m_es;
    int          m_phase;   // 0 run, 1 flush, 2 rebuild

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_hotplug_regs u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .hot_add(hot_add),
        .hot_remove(hot_remove), .cold_add(cold_add), .evt_slot(evt_slot),
        .occupied(occupied), .fixed_slots(fixed_slots), .plat_rst(plat_rst),
        .gpe_ack(gpe_ack), .gpe_hp_sts(gpe_hp_sts), .eject_v(eject_v),
        .eject_slot(eject_slot)
    );

    function automatic int lowest(logic [31:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] reg_val(logic [3:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a)
            4'h0:    return m_pres & m_en;
            4'h4:    return m_down;
            4'hC:    return m_en;
            default: return 32'h0;
        endcase
    endfunction

    // advance the model by one clock using the inputs currently driven
    task automatic model_edge();
        logic [31:0] vec, pn, dn, en;
        int s;
        bit take, run;
        if (!rst_n) begin
            m_pres = '0; m_down = '0; m_en = '1; m_gpe = 0; m_ev = 0; m_es = '0;
            m_rd = '0; m_phase = 2;
            return;
        end
        if (rd_en) m_rd = reg_val(addr);
        run  = (m_phase == 0);
        vec  = (m_phase == 1) ? m_down : wr_data;
        take = (run && wr_en && addr == 4'h8 && wr_data != 0) || (m_phase == 1 && m_down != 0);
        pn = m_pres; dn = m_down; en = m_en;
        if (take) begin
            s = lowest(vec);
            dn[s] = 1'b0;
            if (!fixed_slots[s]) pn[s] = 1'b0;
            m_es = 5'(s);
        end
        m_ev = take;
        if (run && (hot_add || cold_add)) pn[evt_slot] = 1'b1;
        if (run && hot_remove) dn[evt_slot] = 1'b1;
        if (run && (hot_add || hot_remove)) m_gpe = 1;
        else if (gpe_ack) m_gpe = 0;
        if (m_phase == 2) begin pn = occupied; en = ~fixed_slots; end
        case (m_phase)
            0: if (plat_rst) m_phase = 1;
            1: if (m_down == 0) m_phase = 2;
            default: m_phase = 0;
        endcase
        m_pres = pn; m_down = dn; m_en = en;
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rd_en = 0; wr_en = 0; hot_add = 0; hot_remove = 0; cold_add = 0;
        plat_rst = 0; gpe_ack = 0;
    endtask

    // one clock: edge, model update, compare at the falling edge, clear strobes
    task automatic step(string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(req, "eject_v", 32'(eject_v), 32'(m_ev));
        if (m_ev) check(req, "eject_slot", 32'(eject_slot), 32'(m_es));
        check(req, "gpe_hp_sts", 32'(gpe_hp_sts), 32'(m_gpe));
        check(req, "rd_data", rd_data, m_rd);
        idle_inputs();
    endtask

    task automatic rd(string req, logic [3:0] a);
        rd_en = 1; addr = a; step(req);
    endtask

    task automatic wr(string req, logic [3:0] a, logic [31:0] d);
        wr_en = 1; addr = a; wr_data = d; step(req);
    endtask

    task automatic evt(string req, int kind, int s);
        evt_slot = 5'(s);
        if (kind == 0) hot_add = 1;
        else if (kind == 1) hot_remove = 1;
        else cold_add = 1;
        step(req);
    endtask

    // watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            n_bad++;
            $display("FAIL R9 watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        occupied = 32'h0000_F00F;
        fixed_slots = 32'h0000_0001;
        // R1: reset state while held low
        step("R1"); step("R1");
        @(negedge clk); rst_n = 1;
        rd("R1", 4'h0);           // rebuild edge: reads the reset masks
        rd("R1", 4'h0);           // rebuilt: occupied & ~fixed
        rd("R1", 4'hC);
        // R2 / R3: each offset, unaligned and unknown offsets, hold between reads
        rd("R2", 4'h0);
        step("R2");
        rd("R3", 4'h4); rd("R3", 4'h8); rd("R3", 4'hC);
        rd("R3", 4'h2); rd("R3", 4'hE); rd("R3", 4'h1);
        // R7: cold add does not raise the flag
        evt("R7", 2, 9); rd("R7", 4'h0);
        // R6 / R8: hot add raises it; ack with an event keeps it; ack alone clears
        evt("R6", 0, 20); rd("R6", 4'h0);
        gpe_ack = 1; evt("R8", 1, 21);
        gpe_ack = 1; step("R8");
        step("R8");
        // R4: lowest set bit of the mask, zero write does nothing
        evt("R4", 1, 8);
        wr("R4", 4'h8, 32'h0010_0100);
        rd("R4", 4'h4); rd("R4", 4'h0);
        wr("R4", 4'h8, 32'h0);
        // R5: slot marked fixed after rebuild keeps its present bit on eject
        fixed_slots = 32'h0000_0003;
        wr("R5", 4'h8, 32'h0000_0002); rd("R5", 4'h0);
        wr("R5", 4'h8, 32'h0000_1000); rd("R5", 4'h0);
        // R6: collisions of events and eject on the same slot
        evt("R6", 1, 5);
        hot_remove = 1; evt_slot = 5; wr("R6", 4'h8, 32'h0000_0020);
        rd("R6", 4'h4);
        hot_add = 1; evt_slot = 14; wr("R6", 4'h8, 32'h0000_4000);
        rd("R6", 4'h0);
        // R10: writes elsewhere are ignored
        wr("R10", 4'h0, 32'hFFFF_FFFF); wr("R10", 4'h4, 32'hFFFF_FFFF);
        wr("R10", 4'hC, 32'h0); wr("R10", 4'h9, 32'hFFFF_FFFF);
        rd("R10", 4'h0); rd("R10", 4'h4); rd("R10", 4'hC);
        // R9: flush pending removals lowest first, ignore traffic, then rebuild
        evt("R9", 1, 12); evt("R9", 1, 3); evt("R9", 1, 7);
        plat_rst = 1; step("R9");
        hot_add = 1; evt_slot = 30; wr("R9", 4'h8, 32'h8000_0000);
        for (int i = 0; i < 6; i++) begin
            evt_slot = 5'(25 + i); hot_remove = 1; rd("R9", 4'h4);
        end
        rd("R9", 4'h0); rd("R9", 4'hC);
        // seeded random traffic aimed at a narrow slot range
        for (int it = 0; it < 4000; it++) begin
            int op = int'($urandom % 10);
            rd_en = $urandom % 2;
            addr = ($urandom % 4 == 0) ? 4'($urandom) : 4'(($urandom % 4) * 4);
            evt_slot = 5'($urandom % 8);
            if (op < 3) begin
                wr_en = 1; addr = 4'h8; wr_data = ($urandom & $urandom) & 32'h0000_00FF;
                if ($urandom % 2 == 1) hot_remove = 1;
                if ($urandom % 3 == 0) hot_add = 1;
            end else if (op == 3) hot_add = 1;
            else if (op == 4) hot_remove = 1;
            else if (op == 5) cold_add = 1;
            else if (op == 6) gpe_ack = 1;
            else if (op == 7) plat_rst = ($urandom % 6 == 0);
            else if (op == 8) begin
                wr_en = 1; addr = 4'($urandom); wr_data = $urandom;
            end else begin
                occupied = $urandom;
                fixed_slots = $urandom & $urandom & $urandom;
            end
            if ($urandom % 4 == 0) gpe_ack = 1;
            step("R6");
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule